// File: doc/BRIEF.md
# Byte-Write Synchronous SRAM Datapath

This block is the storage and data path of a synchronous static RAM. Each word is split into byte lanes of nine bits. On every rising clock edge it takes one cycle request from the command side. A request is built from a select, a word address, an active-low global write, an active-low byte write, one active-low enable per lane and the write data. The block classifies the request as idle, read or write. Writes land in the array on the capturing edge. Reads return a whole word together with a data-valid flag.

The read return path has two forms, and a mode input picks one of them. That input is latched while reset is high. In flow-through form the word leaves the array combinationally in the cycle right after the capturing edge. In registered form it passes through an output register and comes out one cycle later. The external bidirectional bus is modelled as separate input, output and drive-enable signals. The drive enable is produced here.

The drive enable has three conditions. It is high only while read data is on the output. It drops at once when the asynchronous active-low output enable is high. In registered form it also drops in the cycle after an idle or write request is captured, even when the register still holds valid data. This is single-cycle deselect timing, and it frees the bus for a following write. A read issued with the output enable high is a dummy read. It counts as a normal read and can be followed directly by a write.

Top module: `sbw_dp`

## Requirements
- R1: A selected request with `gw_n`=0 writes all four lanes, whatever `bw_n` and `lane_en_n` are.
- R2: With `gw_n`=1 and `bw_n`=0, only lanes i with `lane_en_n[i]`=0 are written. Lane i is bits [9i+8:9i]. The other lanes keep their contents.
- R3: With `gw_n`=1, `bw_n`=0 and `lane_en_n`=4'b1111, nothing is written. The cycle still counts as a write, so the output is not driven.
- R4: A selected request with `gw_n`=1 and `bw_n`=1 is a read. It returns all 36 bits, whatever `lane_en_n` is.
- R5: With the latched mode at 0 (flow-through), `rd_valid` and the read word appear in the cycle after the edge that captured the read.
- R6: With the latched mode at 1 (registered), `rd_valid` and the read word appear one cycle later than in flow-through mode, from a register.
- R7: `drive_en` is 0 in the cycle after a write request or an unselected request is captured. Otherwise it is high while read data is valid and `oe_n`=0.
- R8: In registered mode, a read followed by an idle or write request gives `rd_valid`=1 with the read word but `drive_en`=0 in that cycle.
- R9: `oe_n`=1 forces `drive_en` to 0 with no clock edge needed. `rd_valid` and the read data are not affected, and a write may follow such a dummy read directly.
- R10: The mode is sampled only while `rst` is high. Changes to `mode_pipe` after reset have no effect on latency.
- R11: Reset clears `rd_valid`, `drive_en` and the output register (`rd_data`=0 in registered mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; mode latched while high |
| mode_pipe | input | 1 | 1 = registered output, 0 = flow-through (static) |
| sel | input | 1 | Request is for this array (1) or idle (0) |
| addr | input | 6 | Word address |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte write, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| wr_data | input | 36 | Write data, lane i in bits [9i+8:9i] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 36 | Read word |
| rd_valid | output | 1 | Read data present on rd_data |
| drive_en | output | 1 | Bus drivers enabled |

## Verification
Writes are tried three ways: global write with assorted lane enables, byte write with mixed lane patterns, and byte write with every lane masked off. Merged read-back values tell these three cases apart. Back-to-back reads, reads followed by idle requests, and reads followed by writes are run in both output modes. These sequences separate the one-cycle and two-cycle latencies and separate valid data from driven data under the deselect timing. Dummy reads with the output enable high, followed straight away by writes, show that the valid flag and the drive enable are independent. A mode change after reset shows that the latched latency holds.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_e;

    typedef struct packed {
        cyc_e                kind;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    wmask;
        logic [DATA_W-1:0]   wdata;
    } req_t;

    function automatic cyc_e classify(input logic sel, input logic gw_n, input logic bw_n);
        if (!sel)
            return CYC_IDLE;
        if (gw_n && bw_n)
            return CYC_RD;
        return CYC_WR;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic bw_n,
                                                   input logic [LANES-1:0] en_n);
        if (!gw_n)
            return '1;
        if (!bw_n)
            return ~en_n;
        return '0;
    endfunction
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
    import sbw_pkg::*;
(
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output req_t              req
);
    always_comb begin
        req.kind  = classify(sel, gw_n, bw_n);
        req.addr  = addr;
        req.wdata = wr_data;
        req.wmask = (req.kind == CYC_WR) ? lane_mask(gw_n, bw_n, lane_en_n) : '0;
    end
endmodule

// File: rtl/sbw_lane_bank.sv
module sbw_lane_bank #(
    parameter int AW = 6,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage
    import sbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_in,
    input  cyc_e              kind_q,
    input  logic [DATA_W-1:0] array_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              drive_en,
    output logic              mode_q
);
    logic [DATA_W-1:0] hold_q;
    logic              hold_vld_q;
    logic              rd_now;

    assign rd_now = (kind_q == CYC_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= mode_in;
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
        end else begin
            hold_vld_q <= rd_now;
            if (rd_now)
                hold_q <= array_word;
        end
    end

    always_comb begin
        if (mode_q) begin
            rd_data  = hold_q;
            rd_valid = hold_vld_q;
        end else begin
            rd_data  = array_word;
            rd_valid = rd_now;
        end
        drive_en = rd_valid && rd_now && !oe_n;
    end
endmodule

// File: rtl/sbw_dp.sv
module sbw_dp
    import sbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pipe,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              drive_en
);
    req_t              req_d;
    cyc_e              kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] array_word;
    logic              mode_q;

    sbw_decode u_dec (
        .sel       (sel),
        .addr      (addr),
        .gw_n      (gw_n),
        .bw_n      (bw_n),
        .lane_en_n (lane_en_n),
        .wr_data   (wr_data),
        .req       (req_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= CYC_IDLE;
            addr_q <= '0;
        end else begin
            kind_q <= req_d.kind;
            addr_q <= req_d.addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sbw_lane_bank #(.AW(ADDR_W), .W(LANE_W)) u_bank (
            .clk   (clk),
            .we    (!rst && req_d.wmask[g]),
            .waddr (req_d.addr),
            .wdata (req_d.wdata[g*LANE_W +: LANE_W]),
            .raddr (addr_q),
            .rdata (array_word[g*LANE_W +: LANE_W])
        );
    end

    sbw_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .mode_in    (mode_pipe),
        .kind_q     (kind_q),
        .array_word (array_word),
        .oe_n       (oe_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .drive_en   (drive_en),
        .mode_q     (mode_q)
    );
endmodule

// File: rtl/sbw_dp_chk.sv
module sbw_dp_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic gw_n,
    input logic bw_n,
    input logic oe_n,
    input logic rd_valid,
    input logic drive_en,
    input logic mode_q
);
    logic rd_req;
    assign rd_req = sel && gw_n && bw_n;

    p_write_hiz_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(sel && !(gw_n && bw_n)) |-> !drive_en);

    p_drive_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> rd_valid);

    p_oe_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en);

    p_flow_latency_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_q && !$past(rst) && $past(rd_req) |-> rd_valid);

    p_pipe_latency_r6: assert property (@(posedge clk) disable iff (rst)
        mode_q && !$past(rst) && !$past(rst, 2) && $past(rd_req, 2) |-> rd_valid);

    p_mode_held_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid && !drive_en);
endmodule

bind sbw_dp sbw_dp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .gw_n     (gw_n),
    .bw_n     (bw_n),
    .oe_n     (oe_n),
    .rd_valid (rd_valid),
    .drive_en (drive_en),
    .mode_q   (mode_q)
);

// File: tb/tb_sbw_dp.sv
module tb_sbw_dp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_pipe = 1'b0;
    logic        sel = 1'b0;
    logic [5:0]  addr = '0;
    logic        gw_n = 1'b1;
    logic        bw_n = 1'b1;
    logic [3:0]  lane_en_n = 4'hF;
    logic [35:0] wr_data = '0;
    logic        oe_n = 1'b0;
    logic [35:0] rd_data;
    logic        rd_valid;
    logic        drive_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit pipe_mode = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int          at;
        logic [35:0] d;
        string       tag;
    } exp_t;
    exp_t        expq[$];
    logic [35:0] shadow [64];

    sbw_dp dut (
        .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .sel(sel), .addr(addr),
        .gw_n(gw_n), .bw_n(bw_n), .lane_en_n(lane_en_n), .wr_data(wr_data),
        .oe_n(oe_n), .rd_data(rd_data), .rd_valid(rd_valid), .drive_en(drive_en)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected read items as they fall due
    always @(posedge clk) begin
        cyc++;
        #3;
        if (!rst) begin
            bit          ev;
            logic [35:0] ed;
            string       et;
            bit          cur_rd;
            bit          ed_drive;
            string       dtag;
            ev = 1'b0; ed = '0; et = "R7";
            if (expq.size() > 0 && expq[0].at == cyc) begin
                exp_t it;
                it = expq.pop_front();
                ev = 1'b1; ed = it.d; et = it.tag;
            end
            cur_rd   = sel && gw_n && bw_n;
            ed_drive = ev && cur_rd && !oe_n;
            check(rd_valid == ev, {et, " rd_valid"}, {35'd0, rd_valid}, {35'd0, ev});
            if (ev)
                check(rd_data === ed, {et, " rd_data"}, rd_data, ed);
            dtag = oe_n ? "R9" : ((ev && !cur_rd) ? "R8" : "R7");
            check(drive_en == ed_drive, {dtag, " drive_en"}, {35'd0, drive_en}, {35'd0, ed_drive});
        end
    end

    task automatic op(input bit s, input logic [5:0] a, input bit g, input bit b,
                      input logic [3:0] en, input logic [35:0] d, input bit oe, input string tag);
        @(negedge clk);
        sel = s; addr = a; gw_n = g; bw_n = b; lane_en_n = en; wr_data = d; oe_n = oe;
        if (s) begin
            if (g && b) begin
                exp_t it;
                it.at = cyc + 1 + (pipe_mode ? 1 : 0);
                it.d = shadow[a];
                it.tag = tag;
                expq.push_back(it);
            end else begin
                for (int i = 0; i < 4; i++)
                    if (!g || !en[i])
                        shadow[a][i*9 +: 9] = d[i*9 +: 9];
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            op(1'b0, 6'd0, 1'b1, 1'b1, 4'hF, 36'd0, 1'b0, "R7");
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst = 1'b1; mode_pipe = m; sel = 1'b0; oe_n = 1'b0;
        pipe_mode = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #4;
        check(rd_valid == 1'b0, "R11 rd_valid after reset", {35'd0, rd_valid}, 36'd0);
        check(drive_en == 1'b0, "R11 drive_en after reset", {35'd0, drive_en}, 36'd0);
        if (m)
            check(rd_data == 36'd0, "R11 output register cleared", rd_data, 36'd0);
    endtask

    task automatic wr_full(input logic [5:0] a, input logic [35:0] d);
        op(1'b1, a, 1'b0, 1'b1, 4'hF, d, 1'b0, "R1");
    endtask

    task automatic rd(input logic [5:0] a, input logic [3:0] en, input bit oe, input string tag);
        op(1'b1, a, 1'b1, 1'b1, en, 36'd0, oe, tag);
    endtask

    initial begin
        // ---------------- flow-through phase ----------------
        do_reset(1'b0);
        wr_full(6'd0, 36'h123456789);                                   // R1 lane enables high
        op(1'b1, 6'd1, 1'b0, 1'b0, 4'b0101, 36'hFEDCBA987, 1'b0, "R1"); // R1 bw low, mixed enables
        rd(6'd0, 4'hF, 1'b0, "R1");
        rd(6'd1, 4'hF, 1'b0, "R1");
        wr_full(6'd2, 36'hAAAAAAAAA);
        op(1'b1, 6'd2, 1'b1, 1'b0, 4'b1010, 36'h555555555, 1'b0, "R2");
        rd(6'd2, 4'hF, 1'b0, "R2");
        wr_full(6'd3, 36'h0F0F0F0F0);
        op(1'b1, 6'd3, 1'b1, 1'b0, 4'hF, 36'hFFFFFFFFF, 1'b0, "R3");    // R3 no-lane write
        rd(6'd3, 4'b0000, 1'b0, "R3");
        rd(6'd2, 4'b0110, 1'b0, "R4");                                   // R4 enables ignored on read
        rd(6'd0, 4'b0000, 1'b0, "R5");                                   // R5 back-to-back
        rd(6'd1, 4'b1001, 1'b0, "R5");
        rd(6'd3, 4'hF, 1'b1, "R9");                                      // R9 dummy read
        op(1'b1, 6'd3, 1'b1, 1'b0, 4'b1110, 36'h000000111, 1'b0, "R9");  // write right after
        rd(6'd3, 4'hF, 1'b0, "R9");
        idle(3);

        // ---------------- registered phase ----------------
        do_reset(1'b1);
        wr_full(6'd10, 36'h13579BDF0);
        wr_full(6'd11, 36'h2468ACE13);
        op(1'b1, 6'd12, 1'b1, 1'b0, 4'b0011, 36'h1FF1FF1FF, 1'b0, "R2");
        rd(6'd10, 4'hF, 1'b0, "R6");
        rd(6'd11, 4'hF, 1'b0, "R6");
        rd(6'd10, 4'hF, 1'b0, "R8");
        idle(1);                                                         // R8 deselect cuts drive
        rd(6'd11, 4'hF, 1'b0, "R8");
        op(1'b1, 6'd13, 1'b0, 1'b1, 4'hF, 36'h0ABCDEF01, 1'b0, "R8");   // R8/R7 write after read
        rd(6'd13, 4'hF, 1'b1, "R9");                                     // R9 dummy read
        op(1'b1, 6'd14, 1'b0, 1'b1, 4'hF, 36'h111222333, 1'b0, "R9");
        rd(6'd14, 4'hF, 1'b0, "R6");
        idle(2);
        @(negedge clk); mode_pipe = 1'b0;                                // R10 change ignored
        rd(6'd13, 4'hF, 1'b0, "R10");
        rd(6'd14, 4'hF, 1'b0, "R10");
        idle(4);
        check(expq.size() == 0, "R6 all expected reads seen", expq.size(), 36'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule